// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is the master side of a three-wire serial link with a chip select. It reads 16-bit words from a 64-word serial EEPROM. A single `start` pulse, together with a word count, makes it read words 0, 1, 2 and so on up to count-1. Each word gets its own select window. In that window the block shifts out a 9-bit read command, checks that the device answers with a dummy zero, and then shifts in the 16 data bits. It closes the word with chip select low and one more clock pulse.

Each word is handed to the consumer as a one-cycle `wordValid` pulse, with the word in `wordData` and its address in `wordIndex`. When the run ends, `done` pulses for one cycle. If the device leaves the data line high where the dummy zero is due, the run stops early, `done` pulses and `err` rises.

The serial clock is slow. Each high phase and each low phase lasts `HALF_CYCLES` system clocks; the default gives about 2 µs at 100 MHz.

Top module: `mw_word_reader`

## Requirements
- R1: After reset, and whenever no run is active, `csOut`, `sclkOut` and `doOut` are low, and `busy`, `wordValid` and `done` are low.
- R2: Each word starts with a 9-bit command sent MSB first: start bit 1, opcode 10, then the 6-bit word address (value 0x180 | address). `doOut` changes only while `sclkOut` is low, and holds steady while `sclkOut` is high.
- R3: `csOut` is high for the whole command and data part of each word, and `doOut` is low whenever `csOut` is low.
- R4: Every bit slot is `HALF_CYCLES` cycles with `sclkOut` low, followed by `HALF_CYCLES` cycles with `sclkOut` high. The first slot of a run begins in the cycle after `start` is captured.
- R5: `diIn` is sampled on the last high cycle of the 9th command slot. If it is 1, the run aborts: in the next cycle `csOut` is low, `busy` is low, `done` pulses and `err` goes high. No further word is delivered. `err` stays high until the next accepted `start`.
- R6: The 16 data bits are sampled from `diIn` on the last high cycle of each of the next 16 slots, MSB first. `wordValid` pulses for one cycle, in the cycle after the 16th sample, carrying the assembled word.
- R7: After each word, one stop slot follows. In it `csOut` is low and `sclkOut` makes one low-then-high pulse. The next word's command starts right after the stop slot.
- R8: Words are read at addresses 0 to count-1 in ascending order, and `wordIndex` equals the address of the word delivered.
- R9: `done` pulses for one cycle, in the cycle after the last stop slot. `start` is ignored while `busy` is high.
- R10: A `start` with `wordCount` equal to 0 produces a `done` pulse in the next cycle. No select window opens and `err` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled when idle) |
| wordCount | input | 7 | Number of words to read, 0 to 64 |
| diIn | input | 1 | Serial data from the device |
| csOut | output | 1 | Chip select to the device |
| sclkOut | output | 1 | Serial clock to the device |
| doOut | output | 1 | Serial data to the device |
| busy | output | 1 | Run in progress |
| wordValid | output | 1 | One-cycle strobe for a delivered word |
| wordData | output | 16 | Delivered word |
| wordIndex | output | 6 | Address of the delivered word |
| done | output | 1 | One-cycle end-of-run strobe |
| err | output | 1 | Dummy-zero check failed in the last run |

## Verification
The bench counts cycles from the first cycle after `start` is captured, and uses that count to predict every output. Pin levels follow from the slot and phase positions. `wordValid` is due exactly 50·H cycles into each word, and `done` is due 52·H cycles per word after the start. On an abort, `done` and `err` are due 18·H cycles into the failing word. The bench compares every output on every falling edge against these positions. A behavioural device on the pins decodes the command at the 9th rising edge of the serial clock and returns the dummy bit and the data bits.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_STOP
  } mw_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cmdPhase;   // command bits are on the data-out pin
    logic loadFirst;  // run accepted: address 0, latch count
    logic nextWord;   // advance to the following address
    logic shiftCmd;   // command slot finished
    logic shiftIn;    // data slot finished, take a bit
    logic emit;       // last data bit taken: present the word
    logic finish;     // run completed normally
    logic fail;       // dummy bit was high
  } mw_strobe_t;

endpackage

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int HALF_CYCLES = 200,
  parameter int CMD_W       = 9,
  parameter int DATA_W      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       countZero,
  input  logic       lastWord,
  input  logic       diIn,
  output logic       csOut,
  output logic       sclkOut,
  output logic       busy,
  output mw_strobe_t stb
);

  localparam int TW    = $clog2(HALF_CYCLES + 1);
  localparam int MAXB  = (DATA_W > CMD_W) ? DATA_W : CMD_W;
  localparam int BW    = $clog2(MAXB + 1);

  mw_state_t      state;
  logic [TW-1:0]  timer;
  logic           phaseHigh;
  logic [BW-1:0]  bitCnt;
  logic           halfDone;
  logic           slotEnd;

  assign halfDone = (timer == TW'(HALF_CYCLES - 1));
  assign slotEnd  = halfDone && phaseHigh && (state != ST_IDLE);

  assign csOut   = (state == ST_CMD) || (state == ST_DATA);
  assign sclkOut = phaseHigh;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    stb          = '0;
    stb.cmdPhase = (state == ST_CMD);
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (countZero) stb.finish    = 1'b1;
          else           stb.loadFirst = 1'b1;
        end
      end
      ST_CMD: begin
        if (slotEnd) begin
          stb.shiftCmd = 1'b1;
          if ((bitCnt == BW'(CMD_W - 1)) && diIn) stb.fail = 1'b1;
        end
      end
      ST_DATA: begin
        if (slotEnd) begin
          stb.shiftIn = 1'b1;
          if (bitCnt == BW'(DATA_W - 1)) stb.emit = 1'b1;
        end
      end
      ST_STOP: begin
        if (slotEnd) begin
          if (lastWord) stb.finish   = 1'b1;
          else          stb.nextWord = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      timer     <= '0;
      phaseHigh <= 1'b0;
      bitCnt    <= '0;
    end else if (state == ST_IDLE) begin
      timer     <= '0;
      phaseHigh <= 1'b0;
      bitCnt    <= '0;
      if (stb.loadFirst) state <= ST_CMD;
    end else begin
      if (halfDone) begin
        timer     <= '0;
        phaseHigh <= !phaseHigh;
      end else begin
        timer <= timer + 1'b1;
      end
      if (slotEnd) begin
        unique case (state)
          ST_CMD: begin
            if (bitCnt == BW'(CMD_W - 1)) begin
              bitCnt <= '0;
              state  <= diIn ? ST_IDLE : ST_DATA;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (bitCnt == BW'(DATA_W - 1)) begin
              bitCnt <= '0;
              state  <= ST_STOP;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_STOP: state <= lastWord ? ST_IDLE : ST_CMD;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mw_dpath.sv
module mw_dpath
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int CMD_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mw_strobe_t        stb,
  input  logic [ADDR_W:0]   wordCount,
  input  logic              diIn,
  output logic              doOut,
  output logic              lastWord,
  output logic              countZero,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData,
  output logic [ADDR_W-1:0] wordIndex,
  output logic              done,
  output logic              err
);

  localparam logic [2:0] READ_HEAD = 3'b110;  // start bit, read opcode

  logic [CMD_W-1:0]  cmdShift;
  logic [DATA_W-1:0] dataShift;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W:0]   countReg;
  logic [ADDR_W-1:0] addrNext;

  assign addrNext  = addr + 1'b1;
  assign doOut     = stb.cmdPhase & cmdShift[CMD_W-1];
  assign lastWord  = (({1'b0, addr}) + 1'b1) == countReg;
  assign countZero = (wordCount == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdShift  <= '0;
      dataShift <= '0;
      addr      <= '0;
      countReg  <= '0;
      wordValid <= 1'b0;
      wordData  <= '0;
      wordIndex <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      wordValid <= stb.emit;
      done      <= stb.finish | stb.fail;
      if (stb.loadFirst) begin
        addr     <= '0;
        countReg <= wordCount;
        cmdShift <= {READ_HEAD, {ADDR_W{1'b0}}};
      end else if (stb.nextWord) begin
        addr     <= addrNext;
        cmdShift <= {READ_HEAD, addrNext};
      end else if (stb.shiftCmd) begin
        cmdShift <= {cmdShift[CMD_W-2:0], 1'b0};
      end
      if (stb.shiftIn) dataShift <= {dataShift[DATA_W-2:0], diIn};
      if (stb.emit) begin
        wordData  <= {dataShift[DATA_W-2:0], diIn};
        wordIndex <= addr;
      end
      if (stb.fail)                        err <= 1'b1;
      else if (stb.loadFirst | stb.finish) err <= 1'b0;
    end
  end

endmodule

// File: rtl/mw_word_reader.sv
module mw_word_reader
  import mw_pkg::*;
#(
  parameter int HALF_CYCLES = 200,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W:0]   wordCount,
  input  logic              diIn,
  output logic              csOut,
  output logic              sclkOut,
  output logic              doOut,
  output logic              busy,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData,
  output logic [ADDR_W-1:0] wordIndex,
  output logic              done,
  output logic              err
);

  localparam int CMD_W = 3 + ADDR_W;

  mw_strobe_t stb;
  logic       lastWord;
  logic       countZero;

  mw_ctrl #(
    .HALF_CYCLES(HALF_CYCLES),
    .CMD_W      (CMD_W),
    .DATA_W     (DATA_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .countZero(countZero),
    .lastWord (lastWord),
    .diIn     (diIn),
    .csOut    (csOut),
    .sclkOut  (sclkOut),
    .busy     (busy),
    .stb      (stb)
  );

  mw_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CMD_W (CMD_W)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .wordCount(wordCount),
    .diIn     (diIn),
    .doOut    (doOut),
    .lastWord (lastWord),
    .countZero(countZero),
    .wordValid(wordValid),
    .wordData (wordData),
    .wordIndex(wordIndex),
    .done     (done),
    .err      (err)
  );

endmodule

// File: rtl/mw_word_reader_chk.sv
module mw_word_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic csOut,
  input logic sclkOut,
  input logic doOut,
  input logic busy,
  input logic wordValid,
  input logic done,
  input logic err
);

  // R2
  dout_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclkOut && $past(sclkOut)) |-> $stable(doOut));

  // R3
  dout_quiet_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csOut |-> !doOut);

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wordValid |=> !wordValid);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !csOut));

  // R5
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!csOut && !sclkOut && !doOut));

endmodule

bind mw_word_reader mw_word_reader_chk u_chk (.*);

// File: tb/mw_word_reader_tb.sv
module mw_word_reader_tb;

  localparam int H      = 3;
  localparam int SLOT   = 2 * H;
  localparam int WP     = 26 * SLOT;
  localparam int NOFAIL = 999;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  wordCount = '0;
  logic        diIn = 1'b0;
  logic        csOut, sclkOut, doOut, busy, wordValid, done, err;
  logic [15:0] wordData;
  logic [5:0]  wordIndex;

  int compared = 0;
  int mismatched = 0;
  int failAddr = NOFAIL;
  int cycles = 0;

  always #5 clk = ~clk;

  mw_word_reader #(.HALF_CYCLES(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wordCount(wordCount),
    .diIn(diIn), .csOut(csOut), .sclkOut(sclkOut), .doOut(doOut),
    .busy(busy), .wordValid(wordValid), .wordData(wordData),
    .wordIndex(wordIndex), .done(done), .err(err)
  );

  function automatic logic [15:0] memWord(int a);
    return 16'hA5C3 ^ (16'(a) * 16'h0731);
  endfunction

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // behavioural serial device
  int   devBits = 0;
  logic [8:0] devCmd = '0;
  int   devAddr = 0;
  always @(posedge sclkOut or negedge csOut) begin
    if (!csOut) begin
      devBits = 0;
      diIn <= 1'b0;
    end else if (sclkOut) begin
      devBits++;
      if (devBits <= 9) devCmd = {devCmd[7:0], doOut};
      if (devBits == 9) begin
        devAddr = int'(devCmd[5:0]);
        chk("R2 command word", int'(devCmd), 9'h180 | devAddr);
        diIn <= (devAddr == failAddr);
      end else if (devBits >= 10 && devBits <= 25) begin
        diIn <= memWord(devAddr)[25 - devBits];
      end
    end
  end

  task automatic runCase(int cnt, int failA, int ignoreAt);
    bit fail;
    int endT;
    failAddr = failA;
    fail = (failA < cnt);
    endT = (cnt == 0) ? 0 : (fail ? failA * WP + 18 * H : cnt * WP);
    wordCount = 7'(cnt);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t <= endT; t++) begin
      if (t < endT) begin
        int w = t / WP;
        int r = t % WP;
        int s = r / SLOT;
        int hi = ((r % SLOT) >= H) ? 1 : 0;
        logic [8:0] cmd = 9'h180 | 9'(w);
        chk("R3 cs level", int'(csOut), (s < 25) ? 1 : 0);
        chk((s == 25) ? "R7 stop pulse" : "R4 sclk phase", int'(sclkOut), hi);
        chk("R2 data-out bit", int'(doOut), (s < 9) ? int'(cmd[8 - s]) : 0);
        chk("R6 valid timing", int'(wordValid), (r == 50 * H) ? 1 : 0);
        chk("R9 busy", int'(busy), 1);
        chk("R9 done early", int'(done), 0);
        chk("R5 err early", int'(err), 0);
        if (r == 50 * H) begin
          chk("R6 word data", int'(wordData), int'(memWord(w)));
          chk("R8 word index", int'(wordIndex), w);
        end
      end else begin
        chk(cnt == 0 ? "R10 done on zero count" : "R9 done at end", int'(done), 1);
        chk(fail ? "R5 err set" : "R10 err clear", int'(err), fail ? 1 : 0);
        chk("R5 cs low at end", int'(csOut), 0);
        chk("R1 sclk idle", int'(sclkOut), 0);
        chk("R1 dout idle", int'(doOut), 0);
        chk("R9 busy end", int'(busy), 0);
        chk("R1 valid idle", int'(wordValid), 0);
      end
      start = (t == ignoreAt) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R9 done single", int'(done), 0);
    chk("R5 err held", int'(err), fail ? 1 : 0);
    chk("R1 busy idle", int'(busy), 0);
    repeat (3) @(negedge clk);
    chk("R1 cs idle", int'(csOut), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cs", int'(csOut), 0);
    chk("R1 reset sclk", int'(sclkOut), 0);
    chk("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle valid", int'(wordValid), 0);
    chk("R1 idle busy", int'(busy), 0);
    runCase(3, NOFAIL, -1);          // R8 small run
    runCase(1, NOFAIL, -1);          // single word
    runCase(5, 2, -1);               // R5 abort on word 2
    runCase(0, NOFAIL, -1);          // R10 zero count clears err
    runCase(4, NOFAIL, 40);          // R9 start while busy ignored
    runCase(2, 0, -1);               // R5 abort on first word
    runCase(64, NOFAIL, 1000);       // R8 full image
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule